// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This block gathers the interrupt sources of an I2C controller into one raw status word, gates that word with a mask register, and drives a single interrupt line. Ten event sources come in as one-cycle pulses from the sequencer and the bus monitor. Each pulse sets a sticky bit that stays set until software clears it. Two FIFO level flags, transmit-empty and receive-full, come in as levels and are carried straight into the status word.

Software clears sticky bits by reading. Each sticky source has its own clear register, so a handler can clear exactly the bits it has already seen. An event that arrives between the status read and the clear is then kept. A combined clear register wipes every sticky bit with a single read. When a transmit abort pulse arrives, the block also records a cause vector. Reading the dedicated abort clear register resets that cause vector to zero.

The register port is a plain word bus. A read strobe with side effects returns the data one cycle later.

Top module: `i2c_irq_hub`

## Requirements
- R1: After reset, every sticky bit, the mask register, the abort cause, the read data and `irq` are zero.
- R2: A pulse on an event input sets its sticky bit at the next edge, and the bit stays set until a clearing read. Raw status bit positions are: 0 rx underflow, 1 rx overflow, 2 tx overflow, 3 read request, 4 tx abort, 5 rx done, 6 activity, 7 stop, 8 start, 9 general call, 10 tx empty, 11 rx full.
- R3: The mask register at address 0x01 is readable and writable over the full data width. The masked status at 0x00 reads as raw status (0x02) AND the low 12 mask bits.
- R4: A read of address 0x05+k (k = 0..9) clears only sticky bit k. It returns the value that bit had before the read in data bit 0, with all other data bits zero.
- R5: A read of address 0x04 clears all ten sticky bits. It returns in bit 0 whether any sticky bit was set before the read.
- R6: Raw bits 10 and 11 follow the tx-empty and rx-full inputs one cycle later, and no read clears them.
- R7: On each tx abort pulse, the cause input is ORed into the cause register, which reads at 0x03. A read of 0x09 resets the cause to zero. A read of 0x04 leaves the cause unchanged.
- R8: If an event pulse, or an abort cause capture, coincides with a read that would clear it, the bit (or the captured cause) ends up set.
- R9: `irq` is registered and equals the OR of the masked status bits of the previous cycle. With a zero mask, `irq` stays low while raw status keeps updating.
- R10: Read data appears on `bus_rdata` the cycle after `bus_rd` and holds until the next read. Unmapped addresses read zero. Writes to any address other than 0x01 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_under | input | 1 | Receive underflow pulse |
| ev_rx_over | input | 1 | Receive overflow pulse |
| ev_tx_over | input | 1 | Transmit overflow pulse |
| ev_rd_req | input | 1 | Read request pulse |
| ev_tx_abort | input | 1 | Transmit abort pulse |
| ev_rx_done | input | 1 | Receive done pulse |
| ev_activity | input | 1 | Bus activity pulse |
| ev_stop | input | 1 | Stop condition pulse |
| ev_start | input | 1 | Start condition pulse |
| ev_gen_call | input | 1 | General call pulse |
| lvl_tx_empty | input | 1 | Transmit FIFO at or below threshold (level) |
| lvl_rx_full | input | 1 | Receive FIFO at or above threshold (level) |
| abort_cause_in | input | CAUSE_W | Abort cause bits, valid with ev_tx_abort |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (with side effects) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt output |

## Verification
The bench aims at the race cases. When a pulse lands in the same cycle as a clearing read of its bit, a design that gives priority to the clear loses the event. The bench then sees a zero where a set bit belongs. When a single-bit clear is issued, a decoder that is off by one, or that also clears a neighbour, shows up in the raw readback taken afterwards. For the cause register, the bench checks that only the dedicated abort clear wipes it and that the combined clear leaves it intact. It also checks that the level bits survive every kind of clearing read and that a zero mask keeps the interrupt line low.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NUM_STICKY = 10;
    localparam int NUM_LEVEL  = 2;
    localparam int NUM_SRC    = NUM_STICKY + NUM_LEVEL;

    // sticky bit positions within the raw status word
    localparam int IDX_RX_UNDER = 0;
    localparam int IDX_RX_OVER  = 1;
    localparam int IDX_TX_OVER  = 2;
    localparam int IDX_RD_REQ   = 3;
    localparam int IDX_TX_ABORT = 4;
    localparam int IDX_RX_DONE  = 5;
    localparam int IDX_ACTIVITY = 6;
    localparam int IDX_STOP     = 7;
    localparam int IDX_START    = 8;
    localparam int IDX_GEN_CALL = 9;

    // register word addresses
    localparam int A_MASKED   = 0;
    localparam int A_MASK     = 1;
    localparam int A_RAW      = 2;
    localparam int A_CAUSE    = 3;
    localparam int A_CLR_ALL  = 4;
    localparam int A_CLR_BASE = 5;

    typedef struct packed {
        logic [NUM_STICKY-1:0] bits;   // per-bit clear requests
        logic                  abort;  // dedicated abort clear read
    } clr_req_t;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sticky_o
);

    logic [N-1:0] sticky_d, sticky_q;

    // set has priority over clear so a colliding event is kept
    always_comb begin
        sticky_d = (sticky_q & ~clr_i) | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    assign sticky_o = sticky_q;

    for (genvar k = 0; k < N; k++) begin : g_chk
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[k] |=> sticky_q[k]);
        p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !ev_i[k]) |=> !sticky_q[k]);
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_q[k] && !clr_i[k]) |=> sticky_q[k]);
    end

endmodule

// File: rtl/irq_abort_capture.sv
module irq_abort_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort_ev_i,
    input  logic [W-1:0] cause_i,
    input  logic         clr_i,
    output logic [W-1:0] cause_o
);

    typedef struct packed {
        logic [W-1:0] cause;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)      st_d.cause = '0;
        if (abort_ev_i) st_d.cause = st_d.cause | cause_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;

    p_cause_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !abort_ev_i) |=> (st_q.cause == '0));
    p_cause_accum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_ev_i |=> ((st_q.cause & $past(cause_i)) == $past(cause_i)));
    p_cause_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !abort_ev_i) |=> $stable(st_q.cause));

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int CAUSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [NUM_SRC-1:0] mask_o,
    output clr_req_t           clr_o,
    output logic [DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
    } rf_st_t;

    rf_st_t    st_d, st_q;
    clr_req_t  clr_d;
    logic [NUM_STICKY-1:0] sticky_now;

    assign sticky_now = raw_i[NUM_STICKY-1:0];

    always_comb begin
        st_d        = st_q;
        clr_d       = '0;
        if (wr_i && addr_i == ADDR_W'(A_MASK)) st_d.mask = wdata_i;
        if (rd_i) begin
            st_d.rdata = '0;
            if (addr_i == ADDR_W'(A_MASKED))
                st_d.rdata = DATA_W'(raw_i & st_q.mask[NUM_SRC-1:0]);
            if (addr_i == ADDR_W'(A_MASK))
                st_d.rdata = st_q.mask;
            if (addr_i == ADDR_W'(A_RAW))
                st_d.rdata = DATA_W'(raw_i);
            if (addr_i == ADDR_W'(A_CAUSE))
                st_d.rdata = DATA_W'(cause_i);
            if (addr_i == ADDR_W'(A_CLR_ALL)) begin
                st_d.rdata = DATA_W'(|sticky_now);
                clr_d.bits = '1;
            end
            for (int k = 0; k < NUM_STICKY; k++) begin
                if (addr_i == ADDR_W'(A_CLR_BASE + k)) begin
                    st_d.rdata  = DATA_W'(sticky_now[k]);
                    clr_d.bits[k] = 1'b1;
                end
            end
            clr_d.abort = (addr_i == ADDR_W'(A_CLR_BASE + IDX_TX_ABORT));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o  = st_q.mask[NUM_SRC-1:0];
    assign clr_o   = clr_d;
    assign rdata_o = st_q.rdata;

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
    p_mask_only_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADDR_W'(A_MASK)) |=> $stable(mask_o));
    p_no_clear_without_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (clr_o == '0));

endmodule

// File: rtl/i2c_irq_hub.sv
module i2c_irq_hub
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int CAUSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_rx_under,
    input  logic               ev_rx_over,
    input  logic               ev_tx_over,
    input  logic               ev_rd_req,
    input  logic               ev_tx_abort,
    input  logic               ev_rx_done,
    input  logic               ev_activity,
    input  logic               ev_stop,
    input  logic               ev_start,
    input  logic               ev_gen_call,
    input  logic               lvl_tx_empty,
    input  logic               lvl_rx_full,
    input  logic [CAUSE_W-1:0] abort_cause_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);

    typedef struct packed {
        logic [NUM_LEVEL-1:0] lvl;
        logic                 irq;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_STICKY-1:0] ev_vec, sticky;
    logic [NUM_SRC-1:0]    raw, mask;
    logic [CAUSE_W-1:0]    cause;
    clr_req_t              clr;

    always_comb begin
        ev_vec               = '0;
        ev_vec[IDX_RX_UNDER] = ev_rx_under;
        ev_vec[IDX_RX_OVER]  = ev_rx_over;
        ev_vec[IDX_TX_OVER]  = ev_tx_over;
        ev_vec[IDX_RD_REQ]   = ev_rd_req;
        ev_vec[IDX_TX_ABORT] = ev_tx_abort;
        ev_vec[IDX_RX_DONE]  = ev_rx_done;
        ev_vec[IDX_ACTIVITY] = ev_activity;
        ev_vec[IDX_STOP]     = ev_stop;
        ev_vec[IDX_START]    = ev_start;
        ev_vec[IDX_GEN_CALL] = ev_gen_call;
    end

    assign raw = {st_q.lvl, sticky};

    always_comb begin
        st_d     = st_q;
        st_d.lvl = {lvl_rx_full, lvl_tx_empty};
        st_d.irq = |(raw & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    irq_sticky_bank #(.N(NUM_STICKY)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev_vec),
        .clr_i    (clr.bits),
        .sticky_o (sticky)
    );

    irq_abort_capture #(.W(CAUSE_W)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_ev_i (ev_tx_abort),
        .cause_i    (abort_cause_in),
        .clr_i      (clr.abort),
        .cause_o    (cause)
    );

    irq_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .wdata_i (bus_wdata),
        .raw_i   (raw),
        .cause_i (cause),
        .mask_o  (mask),
        .clr_o   (clr),
        .rdata_o (bus_rdata)
    );

    assign irq = st_q.irq;

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(raw & mask))));
    p_level_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (raw[NUM_SRC-1:NUM_STICKY] == $past({lvl_rx_full, lvl_tx_empty})));
    p_zero_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq);

endmodule

// File: tb/sim_i2c_irq_hub.sv
module sim_i2c_irq_hub;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int CAUSE_W = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic [9:0] ev = '0;
    logic [1:0] lvl = '0;      // [1] rx full, [0] tx empty
    logic [CAUSE_W-1:0] cause_in = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic wr = 0, rd = 0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic irq;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    i2c_irq_hub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_under(ev[0]), .ev_rx_over(ev[1]), .ev_tx_over(ev[2]),
        .ev_rd_req(ev[3]), .ev_tx_abort(ev[4]), .ev_rx_done(ev[5]),
        .ev_activity(ev[6]), .ev_stop(ev[7]), .ev_start(ev[8]),
        .ev_gen_call(ev[9]),
        .lvl_tx_empty(lvl[0]), .lvl_rx_full(lvl[1]),
        .abort_cause_in(cause_in),
        .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic [9:0]  ev;
        logic [1:0]  lvl;
        logic [11:0] mask;
        logic [11:0] raw;
        logic [11:0] msk;
        logic        irq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{10'h001, 2'b00, 12'hFFF, 12'h001, 12'h001, 1'b1},
        '{10'h3FF, 2'b11, 12'h000, 12'hFFF, 12'h000, 1'b0},
        '{10'h210, 2'b01, 12'h400, 12'h610, 12'h400, 1'b1},
        '{10'h000, 2'b10, 12'h3FF, 12'h800, 12'h000, 1'b0},
        '{10'h0AA, 2'b00, 12'h00F, 12'h0AA, 12'h00A, 1'b1},
        '{10'h155, 2'b11, 12'h800, 12'hD55, 12'h800, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic bus_read_ev(input logic [ADDR_W-1:0] a, input logic [9:0] e,
                               output logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = a; rd = 1; ev = e;
        @(negedge clk);
        rd = 0; ev = '0;
        d = rdata;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_read_ev(a, 10'h000, d);
    endtask

    task automatic pulse(input logic [9:0] e, input logic [CAUSE_W-1:0] c);
        @(negedge clk);
        ev = e; cause_in = c;
        @(negedge clk);
        ev = '0; cause_in = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", 32'(rdata), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rst_n = 1;
        @(negedge clk);
        bus_read(5'h02, d); check("R1 raw", 32'(d), 32'h0);
        bus_read(5'h01, d); check("R1 mask", 32'(d), 32'h0);
        bus_read(5'h03, d); check("R1 cause", 32'(d), 32'h0);
        check("R1 irq after reads", 32'(irq), 32'h0);

        // table walk: R2 R3 R6 R9
        foreach (VECS[i]) begin
            lvl = VECS[i].lvl;
            bus_write(5'h01, 16'(VECS[i].mask));
            bus_read(5'h04, d);
            pulse(VECS[i].ev, '0);
            bus_read(5'h02, d);
            check($sformatf("R2/R6 raw vec%0d", i), 32'(d), 32'(VECS[i].raw));
            bus_read(5'h00, d);
            check($sformatf("R3 masked vec%0d", i), 32'(d), 32'(VECS[i].msk));
            check($sformatf("R9 irq vec%0d", i), 32'(irq), 32'(VECS[i].irq));
        end

        // R3 full-width mask readback
        bus_write(5'h01, 16'hFABC);
        bus_read(5'h01, d); check("R3 mask readback", 32'(d), 32'hFABC);

        // R4 single-bit clears
        lvl = 2'b00;
        bus_read(5'h04, d);
        pulse(10'h3FF, '0);
        bus_read(5'h08, d); check("R4 clr bit3 prior", 32'(d), 32'h1);
        bus_read(5'h02, d); check("R4 raw after clr bit3", 32'(d), 32'h3F7);
        bus_read(5'h08, d); check("R4 clr bit3 again", 32'(d), 32'h0);
        bus_read(5'h05, d); check("R4 clr bit0 prior", 32'(d), 32'h1);
        bus_read(5'h02, d); check("R4 raw after clr bit0", 32'(d), 32'h3F6);

        // R5 combined clear
        bus_read(5'h04, d); check("R5 clr all prior", 32'(d), 32'h1);
        bus_read(5'h02, d); check("R5 raw after clr all", 32'(d), 32'h0);
        bus_read(5'h04, d); check("R5 clr all empty", 32'(d), 32'h0);

        // R6 levels survive clears
        lvl = 2'b11;
        pulse(10'h080, '0);
        bus_read(5'h04, d);
        bus_read(5'h0C, d);
        bus_read(5'h02, d); check("R6 levels kept", 32'(d), 32'hC00);
        lvl = 2'b00;
        @(negedge clk);
        bus_read(5'h02, d); check("R6 levels drop", 32'(d), 32'h0);

        // R7 cause capture and clear
        pulse(10'h010, 16'h00A5);
        pulse(10'h010, 16'h0100);
        bus_read(5'h03, d); check("R7 cause accum", 32'(d), 32'h01A5);
        bus_read(5'h04, d);
        bus_read(5'h03, d); check("R7 cause kept by clr all", 32'(d), 32'h01A5);
        pulse(10'h010, '0);
        bus_read(5'h09, d); check("R7 abort clr prior", 32'(d), 32'h1);
        bus_read(5'h03, d); check("R7 cause wiped", 32'(d), 32'h0);

        // R8 collisions
        bus_read_ev(5'h0C, 10'h080, d); check("R8 stop collide read", 32'(d), 32'h0);
        bus_read(5'h02, d); check("R8 stop kept", 32'(d), 32'h080);
        bus_read_ev(5'h04, 10'h200, d); check("R8 clr all collide read", 32'(d), 32'h1);
        bus_read(5'h02, d); check("R8 gencall kept", 32'(d), 32'h200);
        @(negedge clk);
        addr = 5'h09; rd = 1; ev = 10'h010; cause_in = 16'h0003;
        @(negedge clk);
        rd = 0; ev = '0; cause_in = '0;
        bus_read(5'h03, d); check("R8 cause collide", 32'(d), 32'h0003);
        bus_read(5'h02, d); check("R8 abort kept", 32'(d), 32'h210);

        // R9 zero mask, raw still updates
        bus_write(5'h01, 16'h0000);
        pulse(10'h001, '0);
        bus_read(5'h02, d); check("R9 raw with zero mask", 32'(d), 32'h211);
        check("R9 irq with zero mask", 32'(irq), 32'h0);

        // R10 unmapped, hold, ignored writes
        bus_read(5'h1F, d); check("R10 unmapped", 32'(d), 32'h0);
        bus_read(5'h02, d);
        repeat (4) @(negedge clk);
        check("R10 rdata held", 32'(rdata), 32'h211);
        bus_write(5'h02, 16'hFFFF);
        bus_write(5'h03, 16'hFFFF);
        bus_read(5'h02, d); check("R10 raw write ignored", 32'(d), 32'h211);
        bus_read(5'h03, d); check("R10 cause write ignored", 32'(d), 32'h0003);
        bus_read(5'h01, d); check("R10 mask unchanged", 32'(d), 32'h0000);

        summary();
        $finish;
    end

endmodule